// File: doc/BRIEF.md
# Iterative Divide and Modulo Unit

A multi-cycle integer divider for a processor's fixed-point pipeline. A single strobe starts it with two operands and four mode bits. The mode bits choose word (32-bit) or doubleword (64-bit) width, signed or unsigned arithmetic, the extended dividend form, and quotient or remainder output. The unit resolves one quotient bit per clock in a shift-subtract loop that works on operand magnitudes. A final correction cycle applies signs, detects overflow and forms the 64-bit result. The result appears together with a one-cycle completion strobe.

In the extended form, the dividend is the first operand followed by as many zero bits as the operand width. This lets software build wide-precision division out of word or doubleword steps. Word forms read only the low halves of the operands and return their value in the low half of the result. No condition flags are produced beyond the overflow indication.

Top module: `div_iter_unit`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `ovf` and `result` are all zero.
- R2: Unsigned division (`mode_signed`=0, `mode_mod`=0, `mode_ext`=0) returns the truncated quotient of A by B at the selected width.
- R3: Signed division truncates toward zero. A signed remainder takes the sign of the dividend, and is zero or of smaller magnitude than the divisor.
- R4: With `mode_dword`=0, only bits 31:0 of A and B are used, and bits 63:32 of `result` are zero. With `mode_dword`=1, all 64 bits are used.
- R5: With `mode_ext`=1 and `mode_mod`=0, the dividend is A shifted left by the operand width (32 or 64 bits), filled with zeros, and the quotient is returned.
- R6: With `mode_mod`=1, the remainder of A divided by B is returned instead of the quotient, and `mode_ext` has no effect.
- R7: A divisor that is zero at the selected width sets `ovf`=1 and forces `result` to zero, in every mode.
- R8: For quotient forms, a quotient outside the representable range sets `ovf`=1 and forces `result` to zero. The signed range is [-2^(W-1), 2^(W-1)-1] and the unsigned range is [0, 2^W-1], with W the operand width. Examples are the most negative value divided by -1, and an extended form with |A| >= |B|. A remainder of the most negative value by -1 is 0 with `ovf`=0.
- R9: A start accepted on a clock edge raises `busy` from the next cycle. `done` is a one-cycle pulse with `busy` low, visible W+2 clock edges after the accepting edge is counted as edge 1: 34 in word mode, 66 in doubleword mode.
- R10: `start` asserted while `busy` is high is ignored. It produces no extra `done`, and the running operation's result is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op_a | input | 64 | Dividend operand A |
| op_b | input | 64 | Divisor operand B |
| mode_dword | input | 1 | 1 = 64-bit operands, 0 = 32-bit low halves |
| mode_signed | input | 1 | 1 = two's-complement operands |
| mode_ext | input | 1 | 1 = dividend is A followed by W zero bits (quotient forms only) |
| mode_mod | input | 1 | 1 = return remainder, 0 = return quotient |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 64 | Quotient or remainder, zero on overflow |
| ovf | output | 1 | Zero divisor or unrepresentable quotient |

## Verification
The bench builds the unit with its default 64-bit datapath width. The word modes are therefore the half-width path of the same instance, so one build covers both 32-step and 64-step sequences. A reference model in 132-bit signed arithmetic predicts every result and overflow. It is driven by all sixteen mode combinations over a grid of sign-boundary operands, by random and near-boundary extended operands, and by a start issued mid-operation.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef struct packed {
    logic dword;
    logic sgn;
    logic ext;
    logic modu;
  } div_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  div_mode_t     mode,
  output logic [DW-1:0] a_mag,
  output logic [DW-1:0] b_mag,
  output logic          a_neg,
  output logic          b_neg,
  output logic          ext_big,
  output logic          b_zero
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] LOW_MASK = {{HW{1'b0}}, {HW{1'b1}}};

  logic [DW-1:0] a_sel, b_sel, mask;

  always_comb begin
    mask    = mode.dword ? '1 : LOW_MASK;
    a_sel   = a & mask;
    b_sel   = b & mask;
    a_neg   = mode.sgn & (mode.dword ? a[DW-1] : a[HW-1]);
    b_neg   = mode.sgn & (mode.dword ? b[DW-1] : b[HW-1]);
    a_mag   = a_neg ? ((~a_sel + 1'b1) & mask) : a_sel;
    b_mag   = b_neg ? ((~b_sel + 1'b1) & mask) : b_sel;
    ext_big = (a_mag >= b_mag);
    b_zero  = (b_mag == '0);
  end

endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] rem_in,
  input  logic [DW-1:0] quo_in,
  input  logic [DW-1:0] dvsr,
  output logic [DW-1:0] rem_out,
  output logic [DW-1:0] quo_out
);
  logic [DW+1:0] trial;
  logic          borrow;

  always_comb begin
    trial   = {1'b0, rem_in, quo_in[DW-1]} - {2'b00, dvsr};
    borrow  = trial[DW+1];
    rem_out = borrow ? {rem_in[DW-2:0], quo_in[DW-1]} : trial[DW-1:0];
    quo_out = {quo_in[DW-2:0], ~borrow};
  end

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
  import div_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] quo_mag,
  input  logic [DW-1:0] rem_mag,
  input  div_mode_t     mode,
  input  logic          a_neg,
  input  logic          b_neg,
  input  logic          ext_big,
  input  logic          b_zero,
  output logic [DW-1:0] res,
  output logic          ovf
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] LOW_MASK = {{HW{1'b0}}, {HW{1'b1}}};
  localparam logic [DW-1:0] LIM_W    = {{HW{1'b0}}, 1'b1, {(HW-1){1'b0}}};
  localparam logic [DW-1:0] LIM_D    = {1'b1, {(DW-1){1'b0}}};

  logic          q_neg, r_neg, fit_bad;
  logic [DW-1:0] limit, value, mask;

  always_comb begin
    q_neg   = mode.sgn & (a_neg ^ b_neg);
    r_neg   = mode.sgn & a_neg;
    limit   = mode.dword ? LIM_D : LIM_W;
    mask    = mode.dword ? '1 : LOW_MASK;
    fit_bad = mode.sgn & (q_neg ? (quo_mag > limit) : (quo_mag >= limit));
    ovf     = b_zero | (~mode.modu & (fit_bad | (mode.ext & ext_big)));
    if (mode.modu) value = r_neg ? (~rem_mag + 1'b1) : rem_mag;
    else           value = q_neg ? (~quo_mag + 1'b1) : quo_mag;
    res     = ovf ? '0 : (value & mask);
  end

endmodule

// File: rtl/div_iter_unit.sv
module div_iter_unit
  import div_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          mode_dword,
  input  logic          mode_signed,
  input  logic          mode_ext,
  input  logic          mode_mod,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          ovf
);
  localparam int HW = DW / 2;
  localparam int CW = $clog2(DW + 1);

  div_state_t    state_q;
  div_mode_t     mode_in, mode_q;
  logic [DW-1:0] a_mag, b_mag, rem_q, quo_q, dvsr_q, rem_nx, quo_nx, fix_res;
  logic          a_neg, b_neg, ext_big, b_zero, fix_ovf;
  logic          a_neg_q, b_neg_q, ext_big_q, b_zero_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  always_comb begin
    mode_in.dword = mode_dword;
    mode_in.sgn   = mode_signed;
    mode_in.ext   = mode_ext & ~mode_mod;
    mode_in.modu  = mode_mod;
    accept        = start & (state_q == ST_IDLE);
  end

  div_operand_prep #(.DW(DW)) u_prep (
    .a(op_a), .b(op_b), .mode(mode_in),
    .a_mag(a_mag), .b_mag(b_mag), .a_neg(a_neg), .b_neg(b_neg),
    .ext_big(ext_big), .b_zero(b_zero)
  );

  div_step #(.DW(DW)) u_step (
    .rem_in(rem_q), .quo_in(quo_q), .dvsr(dvsr_q),
    .rem_out(rem_nx), .quo_out(quo_nx)
  );

  div_result_fix #(.DW(DW)) u_fix (
    .quo_mag(quo_q), .rem_mag(rem_q), .mode(mode_q),
    .a_neg(a_neg_q), .b_neg(b_neg_q), .ext_big(ext_big_q), .b_zero(b_zero_q),
    .res(fix_res), .ovf(fix_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mode_q    <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dvsr_q    <= '0;
      cnt_q     <= '0;
      a_neg_q   <= 1'b0;
      b_neg_q   <= 1'b0;
      ext_big_q <= 1'b0;
      b_zero_q  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mode_q    <= mode_in;
            a_neg_q   <= a_neg;
            b_neg_q   <= b_neg;
            ext_big_q <= ext_big;
            b_zero_q  <= b_zero;
            dvsr_q    <= b_mag;
            if (mode_in.ext) begin
              rem_q <= a_mag;
              quo_q <= '0;
            end else begin
              rem_q <= '0;
              quo_q <= mode_in.dword ? a_mag : {a_mag[HW-1:0], {HW{1'b0}}};
            end
            cnt_q   <= mode_in.dword ? CW'(DW) : CW'(HW);
            busy    <= 1'b1;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          result  <= fix_res;
          ovf     <= fix_ovf;
          done    <= 1'b1;
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/div_iter_chk.sv
module div_iter_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          ovf,
  input logic [DW-1:0] result,
  input logic [DW-1:0] op_b,
  input logic          mode_dword
);
  localparam int HW = DW / 2;
  localparam int LW = $clog2(DW + 4) + 1;

  logic          dw_q, bz_q;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dw_q  <= 1'b0;
      bz_q  <= 1'b0;
      lat_q <= '0;
    end else if (start && !busy) begin
      dw_q  <= mode_dword;
      bz_q  <= mode_dword ? (op_b == '0) : (op_b[HW-1:0] == '0);
      lat_q <= LW'(1);
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  busy_done_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == (dw_q ? LW'(DW + 2) : LW'(HW + 2))));
  // R10
  busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (rst) (done && bz_q) |-> ovf);
  // R8
  ovf_zero_chk: assert property (@(posedge clk) disable iff (rst) (done && ovf) |-> (result == '0));
  // R4
  word_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !dw_q) |-> (result[DW-1:HW] == '0));

endmodule

bind div_iter_unit div_iter_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ovf(ovf), .result(result), .op_b(op_b), .mode_dword(mode_dword)
);

// File: tb/sim_div_iter_unit.sv
module sim_div_iter_unit;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] op_a = '0, op_b = '0;
  logic          mode_dword = 1'b0, mode_signed = 1'b0, mode_ext = 1'b0, mode_mod = 1'b0;
  logic          busy, done, ovf;
  logic [DW-1:0] result;

  always #5 clk = ~clk;

  div_iter_unit #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .mode_dword(mode_dword), .mode_signed(mode_signed), .mode_ext(mode_ext),
    .mode_mod(mode_mod), .busy(busy), .done(done), .result(result), .ovf(ovf)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, n_issued = 0, n_done = 0;
  logic [63:0] q_res[$];
  logic        q_ovf[$];
  int          q_lat[$];
  int          q_t0[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [64:0] ref_div(input logic [63:0] a, input logic [63:0] b,
                                          input bit dw, input bit sg, input bit ex, input bit md);
    int w;
    logic [63:0] mask, am, bm;
    logic signed [131:0] av, bv, dv, qv, rv, hi, lo;
    w    = dw ? 64 : 32;
    mask = dw ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    am   = a & mask;
    bm   = b & mask;
    av   = {68'd0, am};
    bv   = {68'd0, bm};
    if (sg && am[w-1]) av = av - (132'sd1 <<< w);
    if (sg && bm[w-1]) bv = bv - (132'sd1 <<< w);
    if (bv == 0) return {1'b1, 64'd0};
    if (md) begin
      rv = av % bv;
      return {1'b0, rv[63:0] & mask};
    end
    dv = ex ? (av <<< w) : av;
    qv = dv / bv;
    hi = sg ? ((132'sd1 <<< (w - 1)) - 1) : ((132'sd1 <<< w) - 1);
    lo = sg ? -(132'sd1 <<< (w - 1)) : 132'sd0;
    if (qv > hi || qv < lo) return {1'b1, 64'd0};
    return {1'b0, qv[63:0] & mask};
  endfunction

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input bit dw, input bit sg,
                        input bit ex, input bit md, input string tag);
    logic [64:0] e;
    while (busy) @(negedge clk);
    e = ref_div(a, b, dw, sg, ex, md);
    q_res.push_back(e[63:0]);
    q_ovf.push_back(e[64]);
    q_lat.push_back(dw ? 66 : 34);
    q_t0.push_back(cyc);
    q_tag.push_back(tag);
    op_a = a; op_b = b;
    mode_dword = dw; mode_signed = sg; mode_ext = ex; mode_mod = md;
    start = 1'b1;
    n_issued++;
    @(negedge clk);
    start = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      n_done++;
      if (q_res.size() == 0) begin
        check(1'b0, "R10 unexpected done", result, 64'd0);
      end else begin
        logic [63:0] er;
        logic        eo;
        int          el, t0;
        string       tg;
        er = q_res.pop_front();
        eo = q_ovf.pop_front();
        el = q_lat.pop_front();
        t0 = q_t0.pop_front();
        tg = q_tag.pop_front();
        check(result == er, {tg, " result"}, result, er);
        check(ovf == eo, {tg, " ovf"}, {63'd0, ovf}, {63'd0, eo});
        check((cyc - t0) == el, "R9 latency", 64'(cyc - t0), 64'(el));
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog actual=%0d expected<=150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [63:0] MAX64 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  initial begin
    logic [63:0] cv [6];
    cv[0] = 64'd0;               cv[1] = 64'd1;
    cv[2] = MAX64;               cv[3] = MIN64;
    cv[4] = 64'h0000_0000_8000_0000;
    cv[5] = 64'h7FFF_FFFF_7FFF_FFFF;

    repeat (3) @(negedge clk);
    // R1 reset state while held
    check(busy == 1'b0, "R1 busy", {63'd0, busy}, 64'd0);
    check(done == 1'b0, "R1 done", {63'd0, done}, 64'd0);
    check(result == '0, "R1 result", result, 64'd0);
    check(ovf == 1'b0, "R1 ovf", {63'd0, ovf}, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 idle after release", {62'd0, busy, done}, 64'd0);

    // R2 unsigned
    run_op(64'd100, 64'd7, 0, 0, 0, 0, "R2 word 100/7");
    run_op(64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 1, 0, 0, 0, "R2 dword big/3");
    run_op(64'd5, 64'd9, 1, 0, 0, 0, "R2 dword 5/9");
    // R3 signed
    run_op(64'hFFFF_FFF9, 64'd2, 0, 1, 0, 0, "R3 word -7/2");
    run_op(64'hFFFF_FFF9, 64'd2, 0, 1, 0, 1, "R3 word -7%2");
    run_op(64'd7, -64'sd2, 1, 1, 0, 1, "R3 dword 7%-2");
    run_op(-64'sd100, -64'sd7, 1, 1, 0, 0, "R3 dword -100/-7");
    // R4 upper halves ignored in word mode
    run_op(64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_000A, 0, 0, 0, 0, "R4 word upper junk");
    run_op(64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_000A, 0, 1, 0, 1, "R4 word mod upper junk");
    // R5 extended
    run_op(64'd1, 64'd3, 0, 0, 1, 0, "R5 word ext 1/3");
    run_op(64'd1, 64'd3, 1, 0, 1, 0, "R5 dword ext 1/3");
    run_op(64'hFFFF_FFFF, 64'd2, 0, 1, 1, 0, "R5 word ext -1/2");
    // R6 modulo, ext ignored
    run_op(64'd1000, 64'd33, 1, 0, 1, 1, "R6 mod ext set");
    run_op(64'd1000, 64'd33, 1, 0, 0, 1, "R6 mod ext clear");
    // R7 zero divisor
    run_op(64'd55, 64'hFFFF_0000_0000_0000, 0, 0, 0, 0, "R7 word zero low half");
    run_op(64'd55, 64'd0, 1, 1, 0, 1, "R7 dword mod zero");
    // R8 overflow
    run_op(64'h8000_0000, 64'hFFFF_FFFF, 0, 1, 0, 0, "R8 word min/-1");
    run_op(MIN64, MAX64, 1, 1, 0, 0, "R8 dword min/-1");
    run_op(MIN64, MAX64, 1, 1, 0, 1, "R8 dword min%-1");
    run_op(64'd7, 64'd7, 0, 0, 1, 0, "R8 word ext a>=b");
    run_op(64'd1, 64'd2, 0, 1, 1, 0, "R8 word signed ext fit edge");

    // R10 start while busy
    run_op(64'd12345, 64'd10, 0, 0, 0, 0, "R10 first op");
    repeat (4) @(negedge clk);
    check(busy == 1'b1, "R9 busy mid-op", {63'd0, busy}, 64'd1);
    op_a = 64'd999; op_b = 64'd1; mode_mod = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    // corner grid, all modes
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int m = 0; m < 16; m++)
          run_op(cv[i], cv[j], m[0], m[1], m[2], m[3], "R8 corner grid");

    // random
    void'($urandom(32'h5EED));
    for (int k = 0; k < 200; k++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k % 4 == 1) b = 64'($urandom % 17);
      if (k % 4 == 2) b = b >> ($urandom % 60);
      if (k[2] && (k % 3 != 0)) a = b >> (1 + $urandom % 8);
      run_op(a, b, k[0], k[1], k[2], k[3], "R3 random");
    end

    while (q_res.size() != 0) @(negedge clk);
    repeat (80) @(negedge clk);
    check(n_done == n_issued, "R10 done count", 64'(n_done), 64'(n_issued));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule